// File: doc/BRIEF.md
# Overlapping Serial 1101 Detector

This block watches a one-bit serial stream, taking one bit per rising clock edge. It raises a single-cycle match flag when the four most recent bits, in arrival order, are 1, 1, 0, 1. The flag is a Mealy output: it comes from the held progress state and the bit on the input in the same cycle. It therefore goes high in the cycle in which the closing 1 is presented, before that bit is clocked in. Matches may overlap, so the last 1 of one match can serve as the first 1 of the next.

Progress is held in two D flip-flops. The codes are 00 (nothing useful seen), 01 (a single 1), 10 (two or more 1s) and 11 (1,1,0). Two pieces of combinational logic read the register: one computes the next code, the other drives the match flag. A synchronous active-low reset returns the register to 00. The match flag is held low while reset is asserted.

Top module: `p1101_detector`

## Requirements
- R1: While `rst_n` is low, `hit` is 0. A rising clock edge with `rst_n` low clears the progress state to 00, so bits received before the reset never contribute to a later match.
- R2: `hit` is 1 only when the progress state is 11 (1,1,0 seen) and `bit_in` is 1 in the same cycle.
- R3: From state 00, a 0 keeps the state at 00 and a 1 moves it to 01. `hit` stays 0.
- R4: From state 01, a 0 returns the state to 00 and a 1 moves it to 10. `hit` stays 0.
- R5: From state 10, a 1 keeps the state at 10 and a 0 moves it to 11. A run of any length of 1s followed by 0,1 therefore produces a match.
- R6: From state 11, a 0 returns the state to 00 with `hit` 0.
- R7: From state 11, a 1 drives `hit` to 1 and moves the state to 01, so overlapping matches are reported (1101101 matches twice).
- R8: For the stream 1 0 0 1 0 1 1 0 1 0 1 1 0 1 1 0 1 applied after reset (positions 0 to 16), `hit` is 1 at positions 8, 13 and 16 only.
- R9: `hit` is combinational from state and input. Changing `bit_in` inside a cycle changes `hit` in that same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `bit_in` is taken on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit for the current cycle |
| hit | output | 1 | High in the cycle the final 1 of 1,1,0,1 is presented |

## Verification
On every clock the assertions check the transition taken out of each of the four codes. They also check that `hit` occurs only in state 11 with a 1 on the input, that a match leaves the machine in state 01, and that `hit` is low during reset. The bench scenarios cover the behaviour that needs a longer history or timing within a cycle. These are the reference stream with matches at 8, 13 and 16, chains of overlapping matches, long runs of 1s before the 0,1, a reset that falls in the middle of a partial pattern, and `hit` following `bit_in` within a cycle.

// File: rtl/p1101_pkg.sv
// Package p1101_pkg
// Shared definitions for the serial 1101 detector: the width of the
// progress register and the four progress codes.
// Assumes: the codes below are fixed; the next-state and output logic decode
// them directly.
package p1101_pkg;

    localparam int PROG_W = 2;

    typedef enum logic [PROG_W-1:0] {
        PG_NONE  = 2'b00,   // no useful prefix
        PG_ONE   = 2'b01,   // a single 1
        PG_ONES  = 2'b10,   // two or more 1s
        PG_ONEZ  = 2'b11    // 1,1,0 seen
    } prog_t;

endpackage

// File: rtl/p1101_next.sv
// Module p1101_next
// Next-state logic of the detector: takes the held progress code and the
// current serial bit and computes the code for the next cycle.
// Assumes: purely combinational; the caller registers the result.
module p1101_next
    import p1101_pkg::*;
(
    input  prog_t cur,
    input  logic  din,
    output prog_t nxt
);

    // Transition table, one branch per progress code.
    always_comb begin
        nxt = PG_NONE;
        unique case (cur)
            PG_NONE: nxt = din ? PG_ONE  : PG_NONE;
            PG_ONE:  nxt = din ? PG_ONES : PG_NONE;
            PG_ONES: nxt = din ? PG_ONES : PG_ONEZ;
            PG_ONEZ: nxt = din ? PG_ONE  : PG_NONE;
            default: nxt = PG_NONE;
        endcase
    end

endmodule

// File: rtl/p1101_out.sv
// Module p1101_out
// Mealy output logic: flags a match when 1,1,0 has been seen and the
// current bit is 1. The flag is forced low while reset is asserted.
// Assumes: rst_n is the same active-low synchronous reset the state register uses.
module p1101_out
    import p1101_pkg::*;
(
    input  logic  rst_n,
    input  prog_t cur,
    input  logic  din,
    output logic  match
);

    // Decode the match from the held state and the live input bit.
    always_comb begin
        match = rst_n && (cur == PG_ONEZ) && din;
    end

    // R1: no match may be flagged while reset is held
    always_comb begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (!match);
        end
    end

endmodule

// File: rtl/p1101_state_reg.sv
// Module p1101_state_reg
// Progress register: one D flip-flop for each bit of the state code,
// cleared by a synchronous active-low reset.
// Assumes: d is valid before each rising edge of clk.
module p1101_state_reg
    import p1101_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  prog_t d,
    output prog_t q
);

    logic [PROG_W-1:0] d_bits;
    logic [PROG_W-1:0] q_bits;

    assign d_bits = d;
    assign q      = prog_t'(q_bits);

    for (genvar i = 0; i < PROG_W; i++) begin : g_dff
        // Capture one state bit per edge, cleared to 0 in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q_bits[i] <= 1'b0;
            else        q_bits[i] <= d_bits[i];
        end
    end

endmodule

// File: rtl/p1101_detector.sv
// Module p1101_detector
// Top of the overlapping serial 1101 detector. A two-bit progress register
// feeds the next-state logic and the Mealy match output.
// Assumes: one serial bit per clock; synchronous active-low reset.
module p1101_detector
    import p1101_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    output logic hit
);

    prog_t cur_st;
    prog_t nxt_st;

    p1101_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt_st),
        .q     (cur_st)
    );

    p1101_next u_next (
        .cur (cur_st),
        .din (bit_in),
        .nxt (nxt_st)
    );

    p1101_out u_out (
        .rst_n (rst_n),
        .cur   (cur_st),
        .din   (bit_in),
        .match (hit)
    );

    // R3: moves out of the idle code
    a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_NONE && !bit_in) |=> (cur_st == PG_NONE));
    a_r3_idle_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_NONE && bit_in) |=> (cur_st == PG_ONE));

    // R4: moves out of the single-1 code
    a_r4_one_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_ONE && !bit_in) |=> (cur_st == PG_NONE));
    a_r4_one_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_ONE && bit_in) |=> (cur_st == PG_ONES));

    // R5: moves out of the many-1s code
    a_r5_ones_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_ONES && bit_in) |=> (cur_st == PG_ONES));
    a_r5_ones_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_ONES && !bit_in) |=> (cur_st == PG_ONEZ));

    // R6: a 0 after 1,1,0 drops back to idle
    a_r6_onez_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == PG_ONEZ && !bit_in) |=> (cur_st == PG_NONE));

    // R2: a match needs state 11 and a 1 on the input
    a_r2_hit_cause: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (cur_st == PG_ONEZ && bit_in));

    // R7: a match leaves the single-1 prefix behind for overlap
    a_r7_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cur_st == PG_ONE));

endmodule

// File: tb/tb_p1101_detector.sv
module tb_p1101_detector;

    logic clk = 1'b0;
    logic rst_n;
    logic bit_in;
    logic hit;

    int n_checks = 0;
    int n_fails  = 0;
    logic [2:0] hist = 3'b000;
    int seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    p1101_detector dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (bit_in),
        .hit    (hit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: hit=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one bit, compare hit with the suffix model, then let it clock in.
    task automatic drive_bit(input logic b, input string req);
        logic exp;
        @(negedge clk);
        bit_in = b;
        #2;
        exp = (seen >= 3) && (hist == 3'b110) && b;
        check(req, hit, exp);
        hist = {hist[1:0], b};
        seen++;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n  = 1'b0;
        bit_in = 1'b1;
        #2;
        check(req, hit, 1'b0);
        @(negedge clk);
        #2;
        check(req, hit, 1'b0);
        rst_n = 1'b1;
        hist  = 3'b000;
        seen  = 0;
    endtask

    task automatic t_reference();
        logic [16:0] s = 17'b1_0_0_1_0_1_1_0_1_0_1_1_0_1_1_0_1;
        logic [16:0] want = 17'b0_0_0_0_0_0_0_0_1_0_0_0_0_1_0_0_1;
        do_reset("R1");
        for (int t = 0; t < 17; t++) begin
            @(negedge clk);
            bit_in = s[16-t];
            #2;
            check("R8", hit, want[16-t]);
            hist = {hist[1:0], s[16-t]};
            seen++;
        end
    endtask

    task automatic t_idle();
        do_reset("R1");
        drive_bit(1'b0, "R3"); drive_bit(1'b0, "R3");
        drive_bit(1'b1, "R3"); drive_bit(1'b0, "R4");
        drive_bit(1'b1, "R4"); drive_bit(1'b0, "R4");
        drive_bit(1'b1, "R4"); drive_bit(1'b1, "R4");
        drive_bit(1'b0, "R5"); drive_bit(1'b1, "R2");
    endtask

    task automatic t_long_ones();
        do_reset("R1");
        for (int k = 0; k < 6; k++) drive_bit(1'b1, "R5");
        drive_bit(1'b0, "R5");
        drive_bit(1'b1, "R5");
    endtask

    task automatic t_break();
        do_reset("R1");
        drive_bit(1'b1, "R6"); drive_bit(1'b1, "R6");
        drive_bit(1'b0, "R6"); drive_bit(1'b0, "R6");
        drive_bit(1'b1, "R6"); drive_bit(1'b0, "R6");
        drive_bit(1'b1, "R6");
    endtask

    task automatic t_overlap();
        logic [9:0] s = 10'b1101101101;
        do_reset("R1");
        for (int t = 9; t >= 0; t--) drive_bit(s[t], "R7");
    endtask

    task automatic t_reset_mid();
        do_reset("R1");
        drive_bit(1'b1, "R1"); drive_bit(1'b1, "R1"); drive_bit(1'b0, "R1");
        do_reset("R1");
        drive_bit(1'b1, "R1");
    endtask

    task automatic t_comb();
        do_reset("R1");
        drive_bit(1'b1, "R9"); drive_bit(1'b1, "R9"); drive_bit(1'b0, "R9");
        @(negedge clk);
        bit_in = 1'b0;
        #1;
        check("R9", hit, 1'b0);
        bit_in = 1'b1;
        #1;
        check("R9", hit, 1'b1);
        bit_in = 1'b0;
        #1;
        check("R9", hit, 1'b0);
        bit_in = 1'b1;
        #1;
        check("R9", hit, 1'b1);
        hist = {hist[1:0], 1'b1};
        seen++;
        drive_bit(1'b0, "R9");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        rst_n  = 1'b0;
        bit_in = 1'b0;
        repeat (2) @(negedge clk);
        t_reference();
        t_idle();
        t_long_ones();
        t_break();
        t_overlap();
        t_reset_mid();
        t_comb();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #2000000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        finish_run();
    end

endmodule